// File: doc/BRIEF.md
# CPU Power Mode Controller

This block decides when the processor core, the peripherals and the system oscillator receive a clock. Software writes a two-bit power-control register through a simple write port. One bit requests a light sleep (idle) and the other a deep sleep (stop). The chosen mode does not take effect at the write itself. It takes effect when the core signals, through an instruction-complete strobe, that an instruction has finished. At that point the block drops the matching clock enables.

The two sleep states end in different ways. In idle, peripherals and interrupt logic keep their clocks, and any interrupt request whose enable bit is set brings the core back. The wake also clears the idle bit in hardware, so the core resumes and services the interrupt. In stop, the oscillator, the peripherals and the core are all gated, and interrupts and the watchdog are dead. Only an external reset or a missing-clock-detector reset, which stays alive, restarts the part. Every accepted reset returns the register to zero and the mode to run. It also raises a one-cycle reset request that carries the restart vector, which is zero.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `rst_req` is 1 and `rst_vec` is 0. The register is cleared, the mode is run (00) and all three clock enables are 1. `rst_req` is 0 from the second cycle after release.
- R2: Bit 0 of the register (idle select) does not change the mode when it is written. The mode becomes idle one cycle after the first `instr_done` strobe that follows the write.
- R3: In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R4: An interrupt with `irq_req[i]` and `irq_en[i]` both 1 during idle returns the mode to run on the next cycle and clears bit 0. A later `instr_done` then leaves the mode at run.
- R5: In idle, interrupt requests whose enable bit is 0 are ignored, and the mode stays idle.
- R6: Bit 1 of the register selects stop. It takes priority over bit 0 when both are set. In stop, all three clock enables are 0.
- R7: In stop, interrupts are ignored even when enabled, and a watchdog reset is ignored.
- R8: In stop, `ext_rst` or `mcd_rst` returns the mode to run on the next cycle. They also raise `rst_req` for that cycle with `rst_vec` 0 and clear the register.
- R9: In run or idle, `ext_rst`, `mcd_rst`, or `wdt_rst` with `wdt_en` 1 produces the R8 reset response. A reset takes priority over a same-cycle interrupt wake. `wdt_rst` with `wdt_en` 0 has no effect.
- R10: Register writes while in idle or stop are ignored.
- R11: `mode` reads 00 for run, 01 for idle and 10 for stop, and never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| instr_done | input | 1 | Instruction-complete strobe from the core |
| wr_en | input | 1 | Power-control register write strobe |
| wr_data | input | 2 | Write data: bit 0 idle select, bit 1 stop select |
| irq_req | input | NUM_IRQ | Interrupt requests, one per source |
| irq_en | input | NUM_IRQ | Interrupt enable mask |
| ext_rst | input | 1 | External reset pin request |
| wdt_rst | input | 1 | Watchdog expiry strobe |
| wdt_en | input | 1 | Watchdog enabled |
| mcd_rst | input | 1 | Missing-clock-detector reset |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt clock enable |
| osc_en | output | 1 | System oscillator enable |
| rst_req | output | 1 | Reset request pulse to the core |
| rst_vec | output | VEC_W | Restart address, valid with rst_req |
| mode | output | 2 | Current mode: 00 run, 01 idle, 10 stop |

## Verification
The bench first writes the idle bit with no completion strobe. A design that slept at the write would halt the core one instruction early. It then sends a masked interrupt, a watchdog expiry with the watchdog disabled, and a register write while asleep. Each of these must leave the mode unchanged. A design that woke on any request, or accepted writes while asleep, would show a mode change. After an interrupt wake, a further completion strobe checks that the idle bit really cleared; otherwise the core would fall straight back asleep. Stop is entered with both bits set, so the priority rule is exercised. There, enabled interrupts and the watchdog must fail to wake, while external and missing-clock resets must succeed.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W = 17,
  parameter logic [VEC_W-1:0] RESTART_VEC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_done,
  input  logic               wr_en,
  input  logic [1:0]         wr_data,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               ext_rst,
  input  logic               wdt_rst,
  input  logic               wdt_en,
  input  logic               mcd_rst,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en,
  output logic               rst_req,
  output logic [VEC_W-1:0]   rst_vec,
  output logic [1:0]         mode
);

  localparam int IDLE_BIT = 0;
  localparam int STOP_BIT = 1;

  typedef enum logic [1:0] {M_RUN = 2'b00, M_IDLE = 2'b01, M_STOP = 2'b10} pm_t;

  pm_t        state;
  logic [1:0] ctl;
  logic       wake;
  logic       rst_hit;

  assign wake    = |(irq_req & irq_en);
  assign rst_hit = ext_rst | mcd_rst | (wdt_en & wdt_rst & (state != M_STOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= M_RUN;
      ctl     <= '0;
      rst_req <= 1'b1;
    end else if (rst_hit) begin
      state   <= M_RUN;
      ctl     <= '0;
      rst_req <= 1'b1;
    end else begin
      rst_req <= 1'b0;
      case (state)
        M_RUN: begin
          if (wr_en) ctl <= wr_data;
          if (instr_done) begin
            if (ctl[STOP_BIT])      state <= M_STOP;
            else if (ctl[IDLE_BIT]) state <= M_IDLE;
          end
        end
        M_IDLE: begin
          if (wake) begin
            state         <= M_RUN;
            ctl[IDLE_BIT] <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign mode       = state;
  assign cpu_clk_en = (state == M_RUN);
  assign per_clk_en = (state != M_STOP);
  assign osc_en     = (state != M_STOP);
  assign rst_vec    = rst_req ? RESTART_VEC : '0;

  p_idle_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_RUN && instr_done && ctl == 2'b01 && !rst_hit) |=> (mode == 2'b01));

  p_irq_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_IDLE && wake && !rst_hit) |=> (mode == 2'b00 && !ctl[IDLE_BIT] && !rst_req));

  p_masked_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_IDLE && !wake && !rst_hit) |=> $stable(mode));

  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_STOP && !ext_rst && !mcd_rst) |=> (mode == 2'b10));

  p_stop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == M_STOP && state != M_STOP) |-> (rst_req && mode == 2'b00));

  p_reset_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst || mcd_rst) |=> (rst_req && mode == 2'b00 && ctl == 2'b00 && rst_vec == RESTART_VEC));

  p_no_sleep_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != M_RUN && !rst_hit && !(state == M_IDLE && wake)) |=> $stable(ctl));

  p_mode_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

endmodule

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
  localparam int NI = 8;
  localparam int VW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_done = 1'b0, wr_en = 1'b0;
  logic [1:0]    wr_data = '0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic          ext_rst = 1'b0, wdt_rst = 1'b0, wdt_en = 1'b0, mcd_rst = 1'b0;
  logic          cpu_clk_en, per_clk_en, osc_en, rst_req;
  logic [VW-1:0] rst_vec;
  logic [1:0]    mode;

  int n_tests = 0;
  int n_fail = 0;
  int e_mode, e_ctl, e_rreq;

  always #2 clk = ~clk;

  pwr_mode_ctl #(.NUM_IRQ(NI), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .wr_en(wr_en), .wr_data(wr_data),
    .irq_req(irq_req), .irq_en(irq_en), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .wdt_en(wdt_en),
    .mcd_rst(mcd_rst), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .rst_req(rst_req), .rst_vec(rst_vec), .mode(mode));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: modes 0 run, 1 idle, 2 stop
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_mode = 0; e_ctl = 0; e_rreq = 1;
    end else if (ext_rst || mcd_rst || (wdt_en && wdt_rst && e_mode != 2)) begin
      e_mode = 0; e_ctl = 0; e_rreq = 1;
    end else begin
      e_rreq = 0;
      if (e_mode == 0) begin
        int nxt;
        nxt = 0;
        if (instr_done) nxt = (e_ctl >= 2) ? 2 : ((e_ctl == 1) ? 1 : 0);
        if (wr_en) e_ctl = int'(wr_data);
        e_mode = nxt;
      end else if (e_mode == 1 && (irq_req & irq_en) != 0) begin
        e_mode = 0;
        e_ctl = e_ctl & 2;
      end
    end
  end

  always @(negedge clk) begin
    chk("R11", "model mode", int'(mode), e_mode);
    chk("R3", "model cpu_clk_en", int'(cpu_clk_en), (e_mode == 0) ? 1 : 0);
    chk("R6", "model per_clk_en", int'(per_clk_en), (e_mode != 2) ? 1 : 0);
    chk("R6", "model osc_en", int'(osc_en), (e_mode != 2) ? 1 : 0);
    chk("R1", "model rst_req", int'(rst_req), e_rreq);
    chk("R1", "model rst_vec", int'(rst_vec), 0);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_ctl(input logic [1:0] v);
    wr_data = v; wr_en = 1'b1; step(1); wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    instr_done = 1'b1; step(1); instr_done = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1", "reset mode", int'(mode), 0);
    chk("R1", "reset rst_req", int'(rst_req), 1);
    chk("R1", "reset cpu_clk_en", int'(cpu_clk_en), 1);
    rst_n = 1'b1;
    chk("R1", "rst_req after release", int'(rst_req), 1);
    chk("R1", "rst_vec after release", int'(rst_vec), 0);
    step(1);
    chk("R1", "rst_req second cycle", int'(rst_req), 0);

    write_ctl(2'b01);
    chk("R2", "mode after write only", int'(mode), 0);
    step(2);
    chk("R2", "mode without strobe", int'(mode), 0);
    done_pulse();
    chk("R2", "idle after strobe", int'(mode), 1);
    chk("R3", "idle cpu_clk_en", int'(cpu_clk_en), 0);
    chk("R3", "idle per_clk_en", int'(per_clk_en), 1);
    chk("R3", "idle osc_en", int'(osc_en), 1);

    write_ctl(2'b10);
    chk("R10", "write in idle", int'(mode), 1);
    irq_en = 8'h02; irq_req = 8'h01; step(3);
    chk("R5", "masked irq", int'(mode), 1);
    wdt_en = 1'b0; wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
    chk("R9", "wdt disabled", int'(mode), 1);
    chk("R9", "wdt disabled rst_req", int'(rst_req), 0);
    irq_req = 8'h02; step(1); irq_req = '0;
    chk("R4", "irq wake mode", int'(mode), 0);
    chk("R4", "irq wake rst_req", int'(rst_req), 0);
    done_pulse();
    chk("R4", "idle bit cleared", int'(mode), 0);
    chk("R10", "stop write in idle dropped", int'(mode), 0);

    write_ctl(2'b11);
    done_pulse();
    chk("R6", "stop priority", int'(mode), 2);
    chk("R6", "stop osc_en", int'(osc_en), 0);
    chk("R6", "stop per_clk_en", int'(per_clk_en), 0);
    irq_req = 8'h02; step(2); irq_req = '0;
    chk("R7", "irq in stop", int'(mode), 2);
    wdt_en = 1'b1; wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
    chk("R7", "wdt in stop", int'(mode), 2);
    chk("R7", "wdt in stop rst_req", int'(rst_req), 0);
    ext_rst = 1'b1; step(1); ext_rst = 1'b0;
    chk("R8", "ext wake mode", int'(mode), 0);
    chk("R8", "ext wake rst_req", int'(rst_req), 1);
    chk("R8", "ext wake rst_vec", int'(rst_vec), 0);
    step(1);
    chk("R8", "rst_req one cycle", int'(rst_req), 0);
    done_pulse();
    chk("R8", "register cleared", int'(mode), 0);

    write_ctl(2'b10);
    done_pulse();
    chk("R6", "stop entry", int'(mode), 2);
    mcd_rst = 1'b1; step(1); mcd_rst = 1'b0;
    chk("R8", "mcd wake mode", int'(mode), 0);
    chk("R8", "mcd wake rst_req", int'(rst_req), 1);

    write_ctl(2'b01);
    done_pulse();
    chk("R2", "idle again", int'(mode), 1);
    wdt_rst = 1'b1; step(1); wdt_rst = 1'b0;
    chk("R9", "wdt in idle mode", int'(mode), 0);
    chk("R9", "wdt in idle rst_req", int'(rst_req), 1);

    write_ctl(2'b01);
    done_pulse();
    irq_req = 8'h02; ext_rst = 1'b1; step(1); irq_req = '0; ext_rst = 1'b0;
    chk("R9", "reset beats irq mode", int'(mode), 0);
    chk("R9", "reset beats irq rst_req", int'(rst_req), 1);
    step(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule